// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (16 x 8)

This block behaves as a very small serial EEPROM of sixteen 8-bit locations that answers on a two-wire bus as a slave. The clock and data lines arrive as plain logic levels and are oversampled by the system clock. The block finds Start and Stop conditions and clock edges in the sampled lines. It answers by pulling the data line low through an open-drain enable. The storage is a register file. A byte write is committed when a Stop arrives, and this starts a self-timed write interval measured in system clocks. During that interval the block ignores its own address, so a master can poll for completion.

A transfer begins with a control byte. Its upper nibble must be `1010`, the next three bits are ignored, and bit 0 selects read (1) or write (0). A write carries a word address and then data. A read sends bytes from the internal pointer for as long as the master acknowledges them. A random read is a write of only the address, followed by a repeated Start and a read control byte.

FSM states: `ST_IDLE` (bus free or transfer ignored), `ST_CTRL` (receiving control byte), `ST_CTRL_ACK` (acknowledging it), `ST_ADDR` / `ST_ADDR_ACK` (word address), `ST_DATA` / `ST_DATA_ACK` (write data), `ST_TX` (shifting a byte out), `ST_TX_ACK` (sampling the master's acknowledge), `ST_TX_NEXT` (loading the following byte). Transitions: any Start goes to `ST_CTRL` and any Stop goes to `ST_IDLE`. The 8th rising clock edge in a receive state moves to its ACK state, or to `ST_IDLE` when the control byte does not match or a write is running. The second falling edge in an ACK state moves on to `ST_ADDR`, `ST_TX` or `ST_DATA`. `ST_DATA_ACK` returns to `ST_DATA`. The 8th rise in `ST_TX` goes to `ST_TX_ACK`. A rise there goes to `ST_TX_NEXT` on an acknowledge and to `ST_IDLE` on a not-acknowledge. A fall in `ST_TX_NEXT` returns to `ST_TX`.

Top module: `twi_eeprom16`

## Requirements
- R1: A control byte whose bits [7:4] equal 1010 is acknowledged. The slave holds SDA low across the 9th clock, and bits [3:1] have no effect. Any other code in bits [7:4] gets no acknowledge, and the transfer is ignored until the next Start.
- R2: While the write interval runs (busy high), no control byte is acknowledged. Once busy has fallen, a matching control byte is acknowledged again.
- R3: In a write, the byte after the control byte sets the pointer from its bits [3:0] only, and bits [7:4] are ignored. Both the address byte and the data byte are acknowledged.
- R4: A Stop after a complete data byte stores that byte at the pointer. It also raises busy for exactly WRITE_CYCLES system clocks.
- R5: A Stop before a complete data byte (inside the address byte or the first data byte) stores nothing and leaves busy low.
- R6: When more than one data byte is sent, the last complete byte replaces the earlier ones. A Stop that comes partway through a later byte aborts the write, so nothing is stored and busy stays low.
- R7: After a byte write the pointer stays on the location just written. A following current-address read returns that location.
- R8: The pointer increments by one after each byte sent and wraps from 15 to 0.
- R9: The sequence address write, repeated Start, read control byte returns the location just addressed. It stores nothing and does not raise busy.
- R10: During a read, a master acknowledge (SDA low on the 9th clock) causes the next byte to be sent. A not-acknowledge leaves SDA released, and SDA is also released after every Stop.
- R11: While wr_inhibit is high at the Stop, the write interval runs but the location keeps its old value.
- R12: After reset, SDA is released, busy is low, the pointer is 0 and every location holds 0x00.
- R13: A Start in any state, even mid-byte, restarts control-byte reception from bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled bus clock line |
| sda_in | input | 1 | Sampled bus data line (wired level) |
| wr_inhibit | input | 1 | Low-supply flag; blocks memory update |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| busy | output | 1 | High during the self-timed write interval |

## Verification
Single-byte writes followed by random reads run from a vector table. The address bytes carry junk in their upper nibble, so correct data on readback shows that only the low four bits load the pointer. Directed sequences then drive the other input patterns. A wrong device code and one with odd don't-care bits separate device matching from acceptance of the ignored bits. Stops placed after 4 address bits, after 4 data bits, after two full data bytes, and after a full byte plus 4 more bits separate a commit from an abort and show the reload rule. Sequential reads that cross location 15, followed by current-address reads after a write, separate increment-after-read and wrap from the no-increment-after-write rule. A control byte sent during busy, and one sent with wr_inhibit high, separate the busy-time NACK from a memory update that was actually suppressed.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT
    } eep_state_t;

    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

endpackage

// File: rtl/eep_line_sampler.sv
module eep_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);

    logic [SYNC_STAGES-1:0] scl_sync;
    logic [SYNC_STAGES-1:0] sda_sync;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
            sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
            scl_q    <= scl_sync[SYNC_STAGES-1];
            sda_q    <= sda_sync[SYNC_STAGES-1];
        end
    end

    assign scl_s    = scl_sync[SYNC_STAGES-1];
    assign sda_s    = sda_sync[SYNC_STAGES-1];
    assign ev_rise  =  scl_s && !scl_q;
    assign ev_fall  = !scl_s &&  scl_q;
    assign ev_start =  scl_s &&  scl_q &&  sda_q && !sda_s;
    assign ev_stop  =  scl_s &&  scl_q && !sda_q &&  sda_s;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_BITS = 4,
    parameter int WIDTH     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] waddr,
    input  logic [WIDTH-1:0]     wdata,
    input  logic [ADDR_BITS-1:0] raddr,
    output logic [WIDTH-1:0]     rdata
);

    localparam int DEPTH = 1 << ADDR_BITS;

    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (launch) begin
            remain <= CNT_W'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/twi_eeprom16.sv
module twi_eeprom16 #(
    parameter int ADDR_BITS    = 4,
    parameter int WRITE_CYCLES = 1000000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic wr_inhibit,
    output logic sda_pull,
    output logic busy
);
    import eep_pkg::*;

    localparam int CNT_W = $clog2(BYTE_W);

    logic scl_s, sda_s, ev_rise, ev_fall, ev_start, ev_stop;

    eep_state_t             state, state_nx;
    logic [CNT_W-1:0]       bit_cnt;
    logic [BYTE_W-1:0]      rx_sh;
    logic [BYTE_W-1:0]      tx_sh;
    logic [BYTE_W-1:0]      dbuf;
    logic                   dfull;
    logic                   rd_sel;
    logic [ADDR_BITS-1:0]   ptr;
    logic                   pull_q;

    logic [BYTE_W-1:0]      rx_byte;
    logic [BYTE_W-1:0]      rdata;
    logic                   last_bit;
    logic                   ctrl_hit;
    logic                   commit;
    logic                   store_we;

    eep_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    eep_store #(.ADDR_BITS(ADDR_BITS), .WIDTH(BYTE_W)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .waddr (ptr),
        .wdata (dbuf),
        .raddr (ptr),
        .rdata (rdata)
    );

    eep_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (commit),
        .busy   (busy)
    );

    assign rx_byte  = {rx_sh[BYTE_W-2:0], sda_s};
    assign last_bit = (bit_cnt == CNT_W'(BYTE_W - 1));
    assign ctrl_hit = (rx_byte[7:4] == DEV_CODE) && !busy;
    // The Stop sequence itself produces one clock rise, so one counted bit
    // after a complete byte still means "no later byte begun".
    assign commit   = ev_stop && (state == ST_DATA) && dfull && (bit_cnt <= CNT_W'(1));
    assign store_we = commit && !wr_inhibit;
    assign sda_pull = pull_q;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (ev_start) begin
            state_nx = ST_CTRL;
        end else if (ev_stop) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_CTRL:     if (ev_rise && last_bit) state_nx = ctrl_hit ? ST_CTRL_ACK : ST_IDLE;
                ST_CTRL_ACK: if (ev_fall && pull_q)   state_nx = rd_sel ? ST_TX : ST_ADDR;
                ST_ADDR:     if (ev_rise && last_bit) state_nx = ST_ADDR_ACK;
                ST_ADDR_ACK: if (ev_fall && pull_q)   state_nx = ST_DATA;
                ST_DATA:     if (ev_rise && last_bit) state_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (ev_fall && pull_q)   state_nx = ST_DATA;
                ST_TX:       if (ev_rise && last_bit) state_nx = ST_TX_ACK;
                ST_TX_ACK:   if (ev_rise)             state_nx = sda_s ? ST_IDLE : ST_TX_NEXT;
                ST_TX_NEXT:  if (ev_fall)             state_nx = ST_TX;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            dbuf    <= '0;
            dfull   <= 1'b0;
            rd_sel  <= 1'b0;
            ptr     <= '0;
            pull_q  <= 1'b0;
        end else if (ev_start || ev_stop) begin
            bit_cnt <= '0;
            dfull   <= 1'b0;
            pull_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_CTRL, ST_ADDR, ST_DATA: begin
                    if (ev_rise) begin
                        rx_sh   <= rx_byte;
                        bit_cnt <= bit_cnt + CNT_W'(1);
                        if (state == ST_DATA && bit_cnt == CNT_W'(1)) begin
                            dfull <= 1'b0;
                        end
                        if (last_bit) begin
                            if (state == ST_CTRL) rd_sel <= rx_byte[0];
                            if (state == ST_ADDR) ptr    <= rx_byte[ADDR_BITS-1:0];
                            if (state == ST_DATA) begin
                                dbuf  <= rx_byte;
                                dfull <= 1'b1;
                            end
                        end
                    end
                end
                ST_CTRL_ACK, ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (ev_fall) begin
                        if (!pull_q) begin
                            pull_q <= 1'b1;
                        end else begin
                            bit_cnt <= '0;
                            if (state == ST_CTRL_ACK && rd_sel) begin
                                tx_sh  <= rdata;
                                pull_q <= ~rdata[BYTE_W-1];
                            end else begin
                                pull_q <= 1'b0;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (ev_rise) begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                        if (last_bit) ptr <= ptr + ADDR_BITS'(1);
                    end else if (ev_fall) begin
                        tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                        pull_q <= ~tx_sh[BYTE_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (ev_fall) pull_q <= 1'b0;
                end
                ST_TX_NEXT: begin
                    if (ev_fall) begin
                        bit_cnt <= '0;
                        tx_sh   <= rdata;
                        pull_q  <= ~rdata[BYTE_W-1];
                    end
                end
                default: begin
                    pull_q <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/eep_checker.sv
module eep_checker #(
    parameter int ADDR_BITS    = 4,
    parameter int WRITE_CYCLES = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 sda_pull,
    input logic                 scl_s,
    input logic                 ev_start,
    input logic                 ev_stop,
    input eep_pkg::eep_state_t  state,
    input logic [ADDR_BITS-1:0] ptr
);
    import eep_pkg::*;

    logic [31:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 32'd1;
        end else begin
            busy_run <= '0;
        end
    end

    // R1: the data line is only driven or released while the clock is low
    assert_pull_scl_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull != $past(sda_pull)) |-> (!$past(scl_s) || $past(ev_start) || $past(ev_stop)));

    // R2: no acknowledge phase while the write interval runs
    assert_no_ack_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state != ST_CTRL_ACK));

    // R4: the write interval begins only on a Stop
    assert_busy_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ev_stop));

    // R4: the write interval lasts exactly WRITE_CYCLES clocks
    assert_busy_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_run == 32'(WRITE_CYCLES)));

    // R7: the pointer does not move when a write is launched
    assert_ptr_hold_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (ptr == $past(ptr)));

    // R10: the line is released whenever the slave is idle
    assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);

endmodule

bind twi_eeprom16 eep_checker #(
    .ADDR_BITS    (ADDR_BITS),
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .sda_pull (sda_pull),
    .scl_s    (scl_s),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .state    (state),
    .ptr      (ptr)
);

// File: tb/sim_twi_eeprom16.sv
module sim_twi_eeprom16;

    localparam int WCYC = 300;
    localparam int Q    = 8;
    localparam int NVEC = 6;
    // {address byte, data byte}
    localparam logic [15:0] VEC [NVEC] = '{16'h03A5, 16'hF75A, 16'h0F3C, 16'h30C3, 16'h8E01, 16'h00FF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wr_inhibit = 1'b0;
    logic sda_pull, busy;
    logic sda_bus;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [16];

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    twi_eeprom16 #(.WRITE_CYCLES(WCYC)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_m),
        .sda_in     (sda_bus),
        .wr_inhibit (wr_inhibit),
        .sda_pull   (sda_pull),
        .busy       (busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1; w(2*Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    w(Q);
        scl_m = 1'b1; w(2*Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; w(Q);
        scl_m = 1'b1; w(Q);
        b = sda_bus;  w(Q);
        scl_m = 1'b0; w(Q);
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(ack);
    endtask

    task automatic put_bits(input logic [7:0] d, input int n);
        for (int i = 7; i > 7 - n; i--) put_bit(d[i]);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(~mack);
    endtask

    // full byte write; returns number of busy cycles seen after the Stop
    task automatic write_byte(input logic [7:0] ab, input logic [7:0] d, output int blen);
        logic a;
        bus_start();
        put_byte(8'hA0, a); chk("R1 ctrl ack", a, 0);
        put_byte(ab, a);    chk("R3 addr ack", a, 0);
        put_byte(d, a);     chk("R3 data ack", a, 0);
        sda_m = 1'b0; w(Q);
        scl_m = 1'b1; w(Q);
        sda_m = 1'b1;
        blen = 0;
        for (int k = 0; k < 20 && !busy; k++) w(1);
        while (busy && blen < 5000) begin blen++; w(1); end
        w(Q);
        if (!wr_inhibit) model[ab[3:0]] = d;
    endtask

    task automatic rand_read(input logic [7:0] ab, output logic [7:0] d);
        logic a;
        bus_start();
        put_byte(8'hA0, a);
        put_byte(ab, a);
        bus_start();
        put_byte(8'hA1, a); chk("R9 read ctrl ack", a, 0);
        get_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic cur_read(output logic [7:0] d);
        logic a;
        bus_start();
        put_byte(8'hA1, a); chk("R1 read ctrl ack", a, 0);
        get_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic a;
        int blen;
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        w(5);
        chk("R12 pull in reset", sda_pull, 0);
        rst_n = 1'b1;
        w(10);
        chk("R12 pull after reset", sda_pull, 0);
        chk("R12 busy after reset", busy, 0);
        cur_read(d);
        chk("R12 location 0 after reset", d, 8'h00);

        // vector table: write then random read back
        for (int v = 0; v < NVEC; v++) begin
            write_byte(VEC[v][15:8], VEC[v][7:0], blen);
            chk("R4 busy length", blen, WCYC);
            rand_read(VEC[v][15:8], d);
            chk("R3 R9 readback", d, VEC[v][7:0]);
            chk("R10 released after stop", sda_pull, 0);
            chk("R9 no busy on random read", busy, 0);
        end

        // R1: wrong device code, then odd don't-care bits
        bus_start(); put_byte(8'h90, a); bus_stop();
        chk("R1 wrong code nack", a, 1);
        bus_start(); put_byte(8'hAE, a); bus_stop();
        chk("R1 dont-care bits ack", a, 0);

        // R2: NACK during write interval
        bus_start(); put_byte(8'hA0, a); put_byte(8'h09, a); put_byte(8'h77, a);
        bus_stop();
        model[9] = 8'h77;
        chk("R4 busy after stop", busy, 1);
        bus_start(); put_byte(8'hA0, a); bus_stop();
        chk("R2 nack while busy", a, 1);
        while (busy) w(1);
        bus_start(); put_byte(8'hA0, a); bus_stop();
        chk("R2 ack after busy", a, 0);

        // R7, R8: pointer after write and after reads
        cur_read(d);
        chk("R7 current read after write", d, model[9]);
        cur_read(d);
        chk("R8 pointer increment", d, model[10]);

        // R8, R10: sequential read across the wrap
        bus_start(); put_byte(8'hA0, a); put_byte(8'h0E, a);
        bus_start(); put_byte(8'hA1, a);
        get_byte(1'b1, d); chk("R10 seq byte 14", d, model[14]);
        get_byte(1'b1, d); chk("R10 seq byte 15", d, model[15]);
        get_byte(1'b1, d); chk("R8 wrap to 0", d, model[0]);
        get_byte(1'b0, d); chk("R8 seq byte 1", d, model[1]);
        chk("R10 released after nack", sda_pull, 0);
        bus_stop();

        // R5: aborts inside data and inside address
        bus_start(); put_byte(8'hA0, a); put_byte(8'h02, a); put_bits(8'hF0, 4); bus_stop();
        chk("R5 partial data no busy", busy, 0);
        bus_start(); put_byte(8'hA0, a); put_bits(8'h0B, 4); bus_stop();
        chk("R5 partial addr no busy", busy, 0);
        rand_read(8'h02, d);
        chk("R5 location unchanged", d, model[2]);

        // R6: reload, then abort in a later byte
        bus_start(); put_byte(8'hA0, a); put_byte(8'h04, a);
        put_byte(8'h11, a); put_byte(8'h22, a); bus_stop();
        chk("R6 reload busy", busy, 1);
        model[4] = 8'h22;
        while (busy) w(1);
        rand_read(8'h04, d);
        chk("R6 last byte stored", d, 8'h22);
        bus_start(); put_byte(8'hA0, a); put_byte(8'h05, a);
        put_byte(8'h33, a); put_bits(8'hCC, 4); bus_stop();
        chk("R6 later partial no busy", busy, 0);
        rand_read(8'h05, d);
        chk("R6 later partial aborts", d, model[5]);

        // R11: write inhibit
        wr_inhibit = 1'b1;
        write_byte(8'h06, 8'h99, blen);
        chk("R11 interval still runs", blen, WCYC);
        wr_inhibit = 1'b0;
        rand_read(8'h06, d);
        chk("R11 location kept", d, model[6]);

        // R13: Start mid-byte restarts control reception
        bus_start(); put_byte(8'hA0, a); put_byte(8'h08, a); put_bits(8'h5A, 5);
        bus_start(); put_byte(8'hA1, a);
        chk("R13 restart ack", a, 0);
        get_byte(1'b0, d); bus_stop();
        chk("R13 read after restart", d, model[8]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule